// File: doc/BRIEF.md
# Typed Register Target on an APB Bus

This block is an APB completer with a register map of four words. Each word follows a different ownership rule. The control word is read-write and drives a control output. The status word is read-only and mirrors a hardware input. The interrupt-flag word is set by hardware pulses and cleared by software writing ones. The command word is write-only: a write to it produces a single-cycle strobe on the hardware side.

Wait states are produced elsewhere and arrive on the `pready` input. A transfer is complete only in the cycle where `psel`, `penable` and `pready` are all high. Every change of state is gated on that completing cycle, so a write stretched by wait states commits once and only once. Read data is combinational and aligned with the completing cycle.

Top module: `apb_typed_regs`

## Requirements
- R1: While `presetn` is low (asynchronous, active low), and after its release until the first write, `ctrl_q`, `cmd_pulse`, `prdata` and `pslverr` are 0, and every register reads 0.
- R2: A write to address 0x0 loads `pwdata` into the control word, one byte lane per set `pstrb` bit (lane k is bits 8k+7:8k). It takes effect only at the clock edge where `psel`, `penable`, `pwrite` and `pready` are all high, and never during a wait cycle. `ctrl_q` shows the stored value, and reading 0x0 returns it.
- R3: A read of address 0x4 returns `hw_status` in the same cycle. A write to 0x4 changes no state.
- R4: A completing write to address 0x8 clears exactly the flag bits written as 1 and leaves the other bits unchanged. A read of 0x8 returns the flags.
- R5: A bit that is high on `irq_set` at a clock edge is 1 in the flag word after that edge, even when a completing write to 0x8 clears the same bit at the same edge.
- R6: A completing write to address 0xC drives `cmd_pulse` to the written data for exactly the one cycle after the completing edge. At all other times `cmd_pulse` is 0, and a read of 0xC returns 0.
- R7: The mapped addresses are those with `paddr[1:0]` equal to 0 and every bit above bit 3 equal to 0. Any other address is a decode error: `pslverr` is 1 while `psel` and `penable` are high, a read returns 0, and a write changes no register.
- R8: While `psel` is low, `prdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Target select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | DW | Write data |
| pstrb | input | DW/8 | Byte-lane write mask for the control word |
| pready | input | 1 | Completion, from the external wait-state logic |
| prdata | output | DW | Read data |
| pslverr | output | 1 | Decode error during the access phase |
| hw_status | input | DW | Hardware status, mirrored at 0x4 |
| irq_set | input | DW | Per-bit interrupt set pulses |
| ctrl_q | output | DW | Control word |
| cmd_pulse | output | DW | Command data, valid for one cycle |

## Verification
The hardware interrupt set and the software write-one-to-clear can hit the same flag bit at the same clock edge. This is provoked in two ways. Random `irq_set` pulses run during random clear writes that have random wait counts. A directed case also holds a set bit through a clear of all ones. A bench model applies the rule that set beats clear, and each read of 0x8 is compared with that model. The directed case must return exactly the bit that was held.

// File: rtl/apb_typed_regs.sv
module apb_typed_regs #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  input  logic [DW/8-1:0] pstrb,
  input  logic          pready,
  output logic [DW-1:0] prdata,
  output logic          pslverr,
  input  logic [DW-1:0] hw_status,
  input  logic [DW-1:0] irq_set,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cmd_pulse
);
  localparam int SW = DW / 8;

  logic [DW-1:0] ctrl_r, irq_r, cmd_r;

  wire       hit   = (paddr[1:0] == 2'b00) && (paddr[AW-1:4] == '0);
  wire [3:0] sel   = hit ? (4'b0001 << paddr[3:2]) : 4'b0000;
  wire       wr_en = psel && penable && pwrite && pready;
  wire [DW-1:0] clr = (wr_en && sel[2]) ? pwdata : '0;

  for (genvar k = 0; k < SW; k++) begin : g_lane
    always_ff @(posedge pclk or negedge presetn)
      if (!presetn)                        ctrl_r[8*k +: 8] <= '0;
      else if (wr_en && sel[0] && pstrb[k]) ctrl_r[8*k +: 8] <= pwdata[8*k +: 8];
  end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      irq_r <= '0;
      cmd_r <= '0;
    end else begin
      irq_r <= (irq_r & ~clr) | irq_set;
      cmd_r <= (wr_en && sel[3]) ? pwdata : '0;
    end

  always_comb begin
    prdata = '0;
    if (psel)
      case (sel)
        4'b0001: prdata = ctrl_r;
        4'b0010: prdata = hw_status;
        4'b0100: prdata = irq_r;
        default: prdata = '0;
      endcase
  end

  assign pslverr   = psel && penable && !hit;
  assign ctrl_q    = ctrl_r;
  assign cmd_pulse = cmd_r;

  // R2
  ctrl_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && pready && paddr == AW'(0)) |=> $stable(ctrl_q));
  // R6
  cmd_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && pready && paddr == AW'(12)) |=> (cmd_pulse == '0));
  // R5
  set_wins_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (irq_set != '0) |=> ((irq_r & $past(irq_set)) == $past(irq_set)));
  // R4
  flags_keep_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && pready && paddr == AW'(8)) |=> ((irq_r & $past(irq_r)) == $past(irq_r)));
  // R7
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr[1:0] != 2'b00) |-> (prdata == '0 && (!penable || pslverr)));
endmodule

// File: tb/apb_typed_regs_tb.sv
module apb_typed_regs_tb;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0, pready = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0, hw_status = 0, irq_set, irq_force = 0;
  logic [3:0]  pstrb = 0;
  logic [31:0] prdata, ctrl_q, cmd_pulse;
  logic        pslverr, rnd_irq = 0, mon_on = 0;
  logic [31:0] m_ctrl, m_irq, m_cmd;
  int n_chk = 0, n_bad = 0, cyc = 0;

  apb_typed_regs u_dut (.pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
    .pstrb, .pready, .prdata, .pslverr, .hw_status, .irq_set, .ctrl_q, .cmd_pulse);

  always #5 pclk = ~pclk;

  function automatic logic valid(input logic [11:0] a);
    return a[1:0] == 2'b00 && a[11:4] == 8'h0;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (!valid(a)) return 32'h0;
    case (a[3:2])
      2'd0: return m_ctrl;
      2'd1: return hw_status;
      2'd2: return m_irq;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge pclk or negedge presetn)
    if (!presetn) begin
      m_ctrl <= 0; m_irq <= 0; m_cmd <= 0;
    end else begin
      logic fire;
      fire = psel && penable && pwrite && pready && valid(paddr);
      if (fire && paddr[3:2] == 2'd0)
        m_ctrl <= (m_ctrl & ~lane_mask(pstrb)) | (pwdata & lane_mask(pstrb));
      m_irq <= (m_irq & ~((fire && paddr[3:2] == 2'd2) ? pwdata : 32'h0)) | irq_set;
      m_cmd <= (fire && paddr[3:2] == 2'd3) ? pwdata : 32'h0;
    end

  always @(negedge pclk)
    irq_set <= rnd_irq ? (($urandom % 3 == 0) ? $urandom : 32'h0) : irq_force;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge pclk)
    if (mon_on) begin
      chk("R2 ctrl_q", ctrl_q, m_ctrl);
      chk("R6 cmd_pulse", cmd_pulse, m_cmd);
    end

  always @(posedge pclk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] s, input int waits,
                      output logic [31:0] rd, output logic [31:0] erd, output logic err);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s; pready = 0;
    @(negedge pclk);
    penable = 1;
    repeat (waits) @(negedge pclk);
    pready = 1;
    #2;
    rd = prdata; erd = exp_rd(a); err = pslverr;
    @(negedge pclk);
    psel = 0; penable = 0; pready = 0; pwrite = 0;
  endtask

  logic [31:0] rd, erd;
  logic        err;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge pclk);
    chk("R1 ctrl_q in reset", ctrl_q, 0);
    chk("R1 cmd_pulse in reset", {31'h0, pslverr} | cmd_pulse, 0);
    presetn = 1;
    mon_on = 1;
    xfer(0, 12'h0, 0, 0, 0, rd, erd, err); chk("R1 ctrl after reset", rd, 0);
    xfer(0, 12'h8, 0, 0, 0, rd, erd, err); chk("R1 flags after reset", rd, 0);

    xfer(1, 12'h0, 32'hA5A5_1234, 4'b0101, 3, rd, erd, err);
    xfer(0, 12'h0, 0, 0, 1, rd, erd, err); chk("R2 lane write", rd, 32'h00A5_0034);

    hw_status = 32'hDEAD_BEEF;
    xfer(1, 12'h4, 32'h1111_1111, 4'hF, 2, rd, erd, err);
    xfer(0, 12'h4, 0, 0, 0, rd, erd, err); chk("R3 status read", rd, 32'hDEAD_BEEF);

    @(negedge pclk); irq_force = 32'h0000_F0F0;
    @(negedge pclk); irq_force = 0;
    xfer(1, 12'h8, 32'h0000_00F0, 0, 2, rd, erd, err);
    xfer(0, 12'h8, 0, 0, 0, rd, erd, err); chk("R4 w1c clear", rd, 32'h0000_F000);

    irq_force = 32'h0000_0020;
    xfer(1, 12'h8, 32'hFFFF_FFFF, 0, 1, rd, erd, err);
    irq_force = 0;
    xfer(0, 12'h8, 0, 0, 0, rd, erd, err); chk("R5 set beats clear", rd, 32'h0000_0020);

    xfer(1, 12'hC, 32'h0BAD_F00D, 0, 3, rd, erd, err);
    xfer(0, 12'hC, 0, 0, 0, rd, erd, err); chk("R6 command reads 0", rd, 0);

    xfer(1, 12'h010, 32'hFFFF_FFFF, 4'hF, 0, rd, erd, err); chk("R7 pslverr high addr", {31'h0, err}, 1);
    xfer(1, 12'h002, 32'hFFFF_FFFF, 4'hF, 1, rd, erd, err); chk("R7 pslverr misaligned", {31'h0, err}, 1);
    xfer(0, 12'h006, 0, 0, 0, rd, erd, err); chk("R7 unmapped read", rd, 0);
    xfer(0, 12'h0, 0, 0, 0, rd, erd, err); chk("R7 ctrl untouched", rd, 32'h00A5_0034);

    @(negedge pclk); paddr = 12'h4; #2; chk("R8 idle prdata", prdata, 0);

    rnd_irq = 1;
    for (int i = 0; i < 500; i++) begin
      logic [11:0] a;
      int r;
      r = $urandom % 10;
      a = (r < 8) ? 12'(r % 4) << 2 : 12'($urandom % 4096);
      if ($urandom % 4 == 0) hw_status = $urandom;
      xfer($urandom % 2 == 1, a, $urandom, 4'($urandom), $urandom % 4, rd, erd, err);
      chk("R7 pslverr", {31'h0, err}, {31'h0, !valid(a)});
      if (!pwrite) chk("R2/R3/R4 random read", rd, erd);
      if (i % 50 == 0) begin
        @(negedge pclk); paddr = 12'($urandom); #2; chk("R8 idle prdata", prdata, 0);
      end
    end
    rnd_irq = 0;
    repeat (3) @(negedge pclk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule